// File: doc/BRIEF.md
# Spread-Spectrum Profile and Settle Controller

This block drives the frequency-offset input of a downstream clock generator. It produces a signed code that traces a symmetric triangle. The triangle's period is a fixed number of reference-clock cycles. Its peak amplitude comes from a single spread-select level: a narrow swing when the level is low and a wide swing when it is high. The same code serves the output clock and every data output, so the whole output side moves together.

The spread-select level may arrive from another clock domain, so it first passes through a flop synchronizer. Whenever the synchronized level changes, the block asserts a blank flag for a fixed settle time and drops its data-valid flag. The surrounding logic uses the blank flag to hold the data outputs low. When the settle timer runs out, blanking ends and data-valid rises. Reset behaves like a select change: the code is cleared and a full settle period starts.

Top module: `ssc_ctrl`

## Requirements
- R1: While reset is high, and on the first clock edge that samples reset high, `offset_code` becomes 0, `blank_out` becomes 1 and `data_valid` becomes 0.
- R2: While the synchronized select is steady, `offset_code` repeats exactly every 2·2^PHASE_LOG2 clock cycles (1024 cycles at default parameters).
- R3: With select low (narrow), the code swings over exactly [-PEAK_NARROW, +PEAK_NARROW]. Units are 0.1 %, so the default of 20 is ±2 %.
- R4: With select high (wide), the code swings over exactly [-PEAK_WIDE, +PEAK_WIDE]. The default of 40 is ±4 %.
- R5: The code is two's complement, CODE_W bits wide. Let H = 2^PHASE_LOG2 and let n be the number of clock edges since reset released (the first edge is n=1). The output after edge n uses m = (n-1) mod 2H and i = m mod H, with P the peak for the current setting. When m < H the value is -P + floor(2P·i/H). Otherwise it is P - floor(2P·i/H). The first value after reset is therefore -P.
- R6: A change on `spread_wide` reaches the outputs on the third rising edge after it is applied: the new peak takes effect and `blank_out` rises on that edge, not earlier (SYNC_STAGES = 2).
- R7: After a detected change, `blank_out` stays high for exactly SETTLE_CYCLES cycles. `data_valid` is always the complement of `blank_out` and rises on the edge where blanking ends.
- R8: A change detected while blanking is active restarts the settle count from zero. The total blank time is then the gap between the two detections plus SETTLE_CYCLES.
- R9: After reset releases, `blank_out` stays high for SETTLE_CYCLES cycles. If the synchronizer's reset value differs from the applied select level, the resulting change restarts the settle count as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_wide | input | 1 | Spread-select level, asynchronous: 1 = wide swing, 0 = narrow swing |
| offset_code | output | CODE_W | Signed frequency-offset code in 0.1 % steps |
| blank_out | output | 1 | High while the data outputs must be held low |
| data_valid | output | 1 | High when output data is valid |

## Verification
The bench builds the block with PHASE_LOG2 = 3 and SETTLE_CYCLES = 40, and keeps the default 20/40 peaks and an 8-bit code. These values make a full triangle period 16 cycles and a settle period 40 cycles. Many periods, several toggles, a retrigger inside a settle window and a reset taken with select high therefore fit in a few hundred cycles. A behavioural model compares every output on every cycle. Separate measurements confirm the exact peaks, the period and each blanking length.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {
    ST_SETTLE = 1'b0,
    ST_LIVE   = 1'b1
  } settle_st_e;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic changed
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign level   = chain[STAGES-1];
  assign changed = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/ssc_tri.sv
module ssc_tri #(
  parameter int PHASE_LOG2  = 9,
  parameter int CODE_W      = 8,
  parameter int PEAK_NARROW = 20,
  parameter int PEAK_WIDE   = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wide,
  output logic signed [CODE_W-1:0] offset
);
  localparam int PH_W   = PHASE_LOG2 + 1;
  localparam int PROD_W = CODE_W + PHASE_LOG2 + 1;

  logic [PH_W-1:0]       phase;
  logic [CODE_W-1:0]     peak;
  logic [PHASE_LOG2-1:0] idx;
  logic                  falling;
  logic [PROD_W-1:0]     span;
  logic [CODE_W-1:0]     step;
  logic [CODE_W-1:0]     nxt;

  always_comb begin
    peak    = wide ? CODE_W'(PEAK_WIDE) : CODE_W'(PEAK_NARROW);
    idx     = phase[PHASE_LOG2-1:0];
    falling = phase[PHASE_LOG2];
    span    = PROD_W'({peak, 1'b0}) * PROD_W'(idx);
    step    = CODE_W'(span >> PHASE_LOG2);
    nxt     = falling ? (peak - step) : (step - peak);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      offset <= '0;
    end else begin
      phase  <= phase + 1'b1;
      offset <= $signed(nxt);
    end
  end

  // R3
  narrow_amp_chk: assert property (@(posedge clk) disable iff (rst)
    !wide |=> (offset <= PEAK_NARROW && offset >= -PEAK_NARROW));
  // R4
  wide_amp_chk: assert property (@(posedge clk) disable iff (rst)
    wide |=> (offset <= PEAK_WIDE && offset >= -PEAK_WIDE));
endmodule

// File: rtl/ssc_settle.sv
module ssc_settle
  import ssc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 32800
) (
  input  logic clk,
  input  logic rst,
  input  logic changed,
  output logic blank,
  output logic valid
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  settle_st_e       st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || changed) begin
      st    <= ST_SETTLE;
      cnt   <= '0;
      blank <= 1'b1;
      valid <= 1'b0;
    end else if (st == ST_SETTLE) begin
      if (cnt == LAST) begin
        st    <= ST_LIVE;
        cnt   <= '0;
        blank <= 1'b0;
        valid <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    changed |=> (blank && !valid && cnt == '0));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    blank != valid);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R7
  live_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LIVE && !changed) |=> (!blank && $stable(cnt)));
endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl #(
  parameter int PHASE_LOG2    = 9,
  parameter int CODE_W        = 8,
  parameter int PEAK_NARROW   = 20,
  parameter int PEAK_WIDE     = 40,
  parameter int SETTLE_CYCLES = 32800,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spread_wide,
  output logic [CODE_W-1:0] offset_code,
  output logic              blank_out,
  output logic              data_valid
);
  logic                     wide_s;
  logic                     sel_chg;
  logic signed [CODE_W-1:0] tri_code;

  ssc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .din     (spread_wide),
    .level   (wide_s),
    .changed (sel_chg)
  );

  ssc_tri #(
    .PHASE_LOG2  (PHASE_LOG2),
    .CODE_W      (CODE_W),
    .PEAK_NARROW (PEAK_NARROW),
    .PEAK_WIDE   (PEAK_WIDE)
  ) i_tri (
    .clk    (clk),
    .rst    (rst),
    .wide   (wide_s),
    .offset (tri_code)
  );

  ssc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_settle (
    .clk     (clk),
    .rst     (rst),
    .changed (sel_chg),
    .blank   (blank_out),
    .valid   (data_valid)
  );

  assign offset_code = tri_code;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (offset_code == '0 && blank_out && !data_valid));
endmodule

// File: tb/test_ssc_ctrl.sv
module test_ssc_ctrl;
  localparam int PL = 3;
  localparam int H  = 1 << PL;
  localparam int ST = 40;
  localparam int PN = 20;
  localparam int PW = 40;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic [CW-1:0] offset_code;
  logic          blank_out;
  logic          data_valid;

  int checks = 0;
  int errors = 0;

  ssc_ctrl #(
    .PHASE_LOG2(PL), .CODE_W(CW), .PEAK_NARROW(PN), .PEAK_WIDE(PW),
    .SETTLE_CYCLES(ST), .SYNC_STAGES(2)
  ) i_ssc_ctrl (
    .clk(clk), .rst(rst), .spread_wide(sel),
    .offset_code(offset_code), .blank_out(blank_out), .data_valid(data_valid)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tri_exp(input int n, input bit w);
    int p, m, i, s;
    p = w ? PW : PN;
    m = n % (2 * H);
    i = m % H;
    s = (2 * p * i) / H;
    return (m < H) ? (s - p) : (p - s);
  endfunction

  // behavioural model: sample history, edge count, remaining blank cycles
  bit  hist[$];
  int  n_edges = 0;
  int  remain = 0;
  int  m_off = 0;
  bit  m_ok = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{1'b0, 1'b0, 1'b0};
      n_edges = 0;
      remain = ST;
      m_off = 0;
    end else begin
      m_off = tri_exp(n_edges, hist[1]);
      n_edges++;
      if (hist[1] != hist[2]) remain = ST;
      else if (remain > 0) remain--;
      hist.push_front(sel);
      void'(hist.pop_back());
    end
    m_ok = 1'b1;
  end

  // per-cycle comparison and blank-length measurement
  int    blen = 0;
  int    exp_len = ST;
  string len_tag = "R9";

  always @(negedge clk) begin
    if (m_ok) begin
      chk($signed(offset_code) == m_off, "R5 offset", $signed(offset_code), m_off);
      chk(blank_out == (remain > 0), "R7 blank", blank_out, remain > 0);
      chk(data_valid == !blank_out, "R7 valid", data_valid, !blank_out);
    end
    if (rst) blen = 0;
    else if (blank_out) blen++;
    else if (blen > 0) begin
      chk(blen == exp_len, len_tag, blen, exp_len);
      blen = 0;
    end
  end

  task automatic measure(input int p, input string tag);
    int a[4*H];
    int mx, mn;
    mx = -1000; mn = 1000;
    for (int k = 0; k < 4 * H; k++) begin
      @(negedge clk);
      a[k] = $signed(offset_code);
      if (a[k] > mx) mx = a[k];
      if (a[k] < mn) mn = a[k];
    end
    chk(mx == p, {tag, " max"}, mx, p);
    chk(mn == -p, {tag, " min"}, mn, -p);
    for (int k = 0; k < 2 * H; k++)
      chk(a[k] == a[k + 2 * H], "R2 period", a[k + 2 * H], a[k]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(offset_code == '0, "R1 offset", offset_code, 0);
    chk(blank_out == 1'b1, "R1 blank", blank_out, 1);
    chk(data_valid == 1'b0, "R1 valid", data_valid, 0);
    len_tag = "R9 reset blank length"; exp_len = ST;
    rst = 1'b0;
    repeat (45) @(negedge clk);
    measure(PN, "R3");

    // narrow -> wide, check synchronizer latency
    len_tag = "R7 blank length"; exp_len = ST;
    sel = 1'b1;
    @(negedge clk); chk(blank_out == 1'b0, "R6 edge1", blank_out, 0);
    @(negedge clk); chk(blank_out == 1'b0, "R6 edge2", blank_out, 0);
    @(negedge clk); chk(blank_out == 1'b1, "R6 edge3", blank_out, 1);
    repeat (47) @(negedge clk);
    measure(PW, "R4");

    // retrigger during settle
    len_tag = "R8 retrigger length"; exp_len = 10 + ST;
    sel = 1'b0;
    repeat (10) @(negedge clk);
    sel = 1'b1;
    repeat (60) @(negedge clk);

    // wide -> narrow
    len_tag = "R7 blank length"; exp_len = ST;
    sel = 1'b0;
    repeat (50) @(negedge clk);
    measure(PN, "R3");

    // reset taken with select high
    sel = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(offset_code == '0, "R1 offset", offset_code, 0);
    chk(blank_out == 1'b1, "R1 blank", blank_out, 1);
    chk(data_valid == 1'b0, "R1 valid", data_valid, 0);
    len_tag = "R9 reset with select high"; exp_len = 3 + ST;
    rst = 1'b0;
    repeat (50) @(negedge clk);
    measure(PW, "R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule